// File: doc/BRIEF.md
# I2C Control Register and Operating-Mode Controller

This block holds the control register of an I2C bus interface and works out the interface's operating mode. The control register carries four bits: interface enable, interrupt enable, master select and transmit select. The two mode bits are driven by the CPU and by hardware. When arbitration is lost, hardware drops a master back to slave receive. In slave receive with the addressing format, the R/W bit of the first frame after a start sets the transmit bit. A CPU change to the transmit bit made while a transfer is in progress is held as pending. It is applied when the current acknowledged frame completes, or when the transfer ends.

The CPU reaches the block through a small register window. Offset 0 is the control register and is always reachable. Offsets 1 and 2 are shared: while the interface is disabled they reach the primary and extended slave-address registers, and while it is enabled they reach the mode and data registers. A bit-level engine supplies the event strobes: start, stop, frame-with-ack complete, arbitration lost, and a received R/W bit with its valid flag. The block returns the current mode and the pin-drive enable.

Top module: `i2c_mode_ctl`

## Requirements
- R1: After reset, the control register reads 0x00, mst_o, tx_o and irq_o are 0, and pins_en_o is 0.
- R2: While the enable bit (control bit 7) is 0, pins_en_o is 0, the transfer-active state and any pending transmit write are cleared one cycle later, and all event strobes are ignored. While the enable bit is 1, pins_en_o is 1.
- R3: Offsets 1 and 2 reach the primary and extended address registers while enable is 0, and the mode and data registers while enable is 1. A write reaches only the set that is currently selected. Offset 3 reads 0.
- R4: irq_o equals irq_src_i ANDed with the interrupt-enable bit (control bit 6) and the enable bit. When interrupt enable is 0, irq_o is 0.
- R5: With enable 1 and master set, arb_lost_i clears both the master bit and the transmit bit at the next edge, which gives slave receive.
- R6: With enable 1, in slave receive (master 0, transmit 0), with format bit 0 of the primary address register at 0, and during the first frame after a start, rw_valid_i loads tx_o from rw_bit_i at the next edge. At other times rw_valid_i has no effect.
- R7: While a transfer is active (from start_det_i to stop_det_i, with enable 1), a CPU write to transmit bit 4 leaves tx_o unchanged. The written value is applied at the edge of the next frame_done_i.
- R8: When no transfer is active, a CPU write to bit 4 takes effect at the next edge. A stop with a write still pending applies that write at the stop edge. The master bit (bit 5) is always written at once.
- R9: When a hardware override (arbitration loss or an accepted R/W bit) falls in the same cycle as a pending transmit write, or in any cycle while that write waits, the override sets tx_o and the pending write is discarded.
- R10: The control register reads {enable, irq-enable, master, transmit, 4'b0}. Master and transmit encode the mode: 00 slave receive, 01 slave transmit, 10 master receive, 11 master transmit. mst_o and tx_o show these two bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | CPU write strobe |
| addr_i | input | 2 | CPU register offset |
| wdata_i | input | 8 | CPU write data |
| rdata_o | output | 8 | CPU read data for addr_i |
| start_det_i | input | 1 | Start condition detected |
| stop_det_i | input | 1 | Stop condition detected |
| frame_done_i | input | 1 | Frame including acknowledge completed |
| arb_lost_i | input | 1 | Arbitration lost |
| rw_valid_i | input | 1 | Received R/W bit is valid |
| rw_bit_i | input | 1 | Received R/W bit (1 = transmit) |
| irq_src_i | input | 1 | Raw interrupt request from the engine |
| irq_o | output | 1 | Gated interrupt request to the CPU |
| pins_en_o | output | 1 | SCL/SDA driven by the interface, not the port |
| mst_o | output | 1 | Master bit |
| tx_o | output | 1 | Transmit bit |

## Verification
The transmit bit has two sources that can meet in one cycle: a deferred CPU write that is waiting for its frame, and a hardware override. The bench leaves a write pending and then, in separate scenarios, raises a received R/W bit together with frame_done_i, or raises arbitration loss before the frame completes. It expects the override value in tx_o, and it expects a later frame_done_i not to bring the discarded write back. A behavioural reference model that is updated on every clock edge judges these cycles, as it judges all the others.

// File: rtl/i2c_mode_pkg.sv
package i2c_mode_pkg;
  localparam int unsigned CtlEnBit  = 7;
  localparam int unsigned CtlIeBit  = 6;
  localparam int unsigned CtlMstBit = 5;
  localparam int unsigned CtlTxBit  = 4;
  localparam int unsigned FmtBit    = 0;

  typedef enum logic [1:0] {
    OFS_CTRL = 2'd0,
    OFS_SEL0 = 2'd1,
    OFS_SEL1 = 2'd2,
    OFS_NONE = 2'd3
  } ofs_e;
endpackage

// File: rtl/i2c_win_regs.sv
module i2c_win_regs
  import i2c_mode_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned NSET   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] ctrl_rd_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              fmt_o
);
  // bank 0: address registers (enable = 0), bank 1: mode/data (enable = 1)
  logic [DATA_W-1:0] regs_q [2][NSET];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    for (genvar s = 0; s < NSET; s++) begin : g_slot
      localparam logic [ADDR_W-1:0] SlotOfs = ADDR_W'(s + 1);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q[b][s] <= '0;
        else if (we_i && addr_i == SlotOfs && en_i == (b == 1))
          regs_q[b][s] <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFS_CTRL)) rdata_o = ctrl_rd_i;
    for (int s = 0; s < NSET; s++)
      if (addr_i == ADDR_W'(s + 1)) rdata_o = regs_q[en_i][s];
  end

  assign fmt_o = regs_q[0][0][FmtBit];
endmodule

// File: rtl/i2c_xfer_track.sv
module i2c_xfer_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic start_i,
  input  logic stop_i,
  input  logic frame_done_i,
  output logic active_o,
  output logic first_o
);
  logic active_d, first_d;

  always_comb begin
    active_d = 1'b0;
    first_d  = 1'b0;
    if (en_i) begin
      active_d = start_i | (active_o & ~stop_i);
      first_d  = start_i | (first_o & ~frame_done_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      first_o  <= 1'b0;
    end else begin
      active_o <= active_d;
      first_o  <= first_d;
    end
  end
endmodule

// File: rtl/i2c_mode_fsm.sv
module i2c_mode_fsm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic ctl_we_i,
  input  logic wr_mst_i,
  input  logic wr_tx_i,
  input  logic active_i,
  input  logic first_i,
  input  logic fmt_i,
  input  logic stop_i,
  input  logic frame_done_i,
  input  logic arb_lost_i,
  input  logic rw_valid_i,
  input  logic rw_bit_i,
  output logic mst_o,
  output logic tx_o,
  output logic pend_o
);
  logic pval_q;
  logic mst_d, tx_d, pend_d, pval_d;
  logic arb_hit, rw_hit, defer;

  assign arb_hit = en_i & arb_lost_i & mst_o;
  assign rw_hit  = en_i & rw_valid_i & first_i & ~mst_o & ~tx_o & ~fmt_i;
  assign defer   = en_i & active_i;

  always_comb begin
    mst_d  = mst_o;
    tx_d   = tx_o;
    pend_d = pend_o;
    pval_d = pval_q;
    if (pend_o && en_i && (frame_done_i || stop_i)) begin
      tx_d   = pval_q;
      pend_d = 1'b0;
    end
    if (ctl_we_i) begin
      mst_d = wr_mst_i;
      if (defer) begin
        pend_d = 1'b1;
        pval_d = wr_tx_i;
      end else begin
        tx_d = wr_tx_i;
      end
    end
    if (rw_hit) begin
      tx_d   = rw_bit_i;
      pend_d = 1'b0;
    end
    if (arb_hit) begin
      mst_d  = 1'b0;
      tx_d   = 1'b0;
      pend_d = 1'b0;
    end
    if (!en_i) pend_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mst_o  <= 1'b0;
      tx_o   <= 1'b0;
      pend_o <= 1'b0;
      pval_q <= 1'b0;
    end else begin
      mst_o  <= mst_d;
      tx_o   <= tx_d;
      pend_o <= pend_d;
      pval_q <= pval_d;
    end
  end
endmodule

// File: rtl/i2c_mode_ctl.sv
module i2c_mode_ctl
  import i2c_mode_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              start_det_i,
  input  logic              stop_det_i,
  input  logic              frame_done_i,
  input  logic              arb_lost_i,
  input  logic              rw_valid_i,
  input  logic              rw_bit_i,
  input  logic              irq_src_i,
  output logic              irq_o,
  output logic              pins_en_o,
  output logic              mst_o,
  output logic              tx_o
);
  localparam int unsigned NSet = (1 << ADDR_W) - 2;

  logic en_q, ie_q, ctl_we;
  logic active, first, fmt, pend;
  logic [DATA_W-1:0] ctl_rd;

  assign ctl_we = we_i && addr_i == ADDR_W'(OFS_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0;
      ie_q <= 1'b0;
    end else if (ctl_we) begin
      en_q <= wdata_i[CtlEnBit];
      ie_q <= wdata_i[CtlIeBit];
    end
  end

  always_comb begin
    ctl_rd = '0;
    ctl_rd[CtlEnBit]  = en_q;
    ctl_rd[CtlIeBit]  = ie_q;
    ctl_rd[CtlMstBit] = mst_o;
    ctl_rd[CtlTxBit]  = tx_o;
  end

  i2c_win_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NSET(NSet)) u_regs (
    .clk_i, .rst_ni, .en_i(en_q), .we_i, .addr_i, .wdata_i,
    .ctrl_rd_i(ctl_rd), .rdata_o, .fmt_o(fmt)
  );

  i2c_xfer_track u_track (
    .clk_i, .rst_ni, .en_i(en_q), .start_i(start_det_i), .stop_i(stop_det_i),
    .frame_done_i, .active_o(active), .first_o(first)
  );

  i2c_mode_fsm u_fsm (
    .clk_i, .rst_ni, .en_i(en_q), .ctl_we_i(ctl_we),
    .wr_mst_i(wdata_i[CtlMstBit]), .wr_tx_i(wdata_i[CtlTxBit]),
    .active_i(active), .first_i(first), .fmt_i(fmt), .stop_i(stop_det_i),
    .frame_done_i, .arb_lost_i, .rw_valid_i, .rw_bit_i,
    .mst_o, .tx_o, .pend_o(pend)
  );

  assign pins_en_o = en_q;
  assign irq_o     = irq_src_i & ie_q & en_q;
endmodule

// File: rtl/i2c_mode_ctl_chk.sv
module i2c_mode_ctl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_q,
  input logic ie_q,
  input logic active,
  input logic pend,
  input logic first,
  input logic fmt,
  input logic ctl_we,
  input logic arb_lost_i,
  input logic rw_valid_i,
  input logic rw_bit_i,
  input logic frame_done_i,
  input logic stop_det_i,
  input logic irq_o,
  input logic pins_en_o,
  input logic mst_o,
  input logic tx_o
);
  a_r2_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pins_en_o |=> !active && !pend);

  a_r4_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie_q |-> !irq_o);

  a_r5_arb_to_slave_rx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q && arb_lost_i && mst_o |=> !mst_o && !tx_o);

  a_r6_rw_loads_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q && rw_valid_i && first && !mst_o && !tx_o && !fmt |=> tx_o == $past(rw_bit_i));

  a_r7_tx_deferred: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q && active && ctl_we && !pend && !arb_lost_i && !rw_valid_i
      && !frame_done_i && !stop_det_i |=> $stable(tx_o) && pend);

  a_r9_override_drops_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q && arb_lost_i && mst_o && !ctl_we |=> !pend);
endmodule

bind i2c_mode_ctl i2c_mode_ctl_chk u_chk (
  .clk_i, .rst_ni, .en_q, .ie_q, .active, .pend, .first, .fmt, .ctl_we,
  .arb_lost_i, .rw_valid_i, .rw_bit_i, .frame_done_i, .stop_det_i,
  .irq_o, .pins_en_o, .mst_o, .tx_o
);

// File: tb/i2c_mode_ctl_bench.sv
module i2c_mode_ctl_bench;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic we = 0, start = 0, stop = 0, fdone = 0, arb = 0, rwv = 0, rwb = 0, isrc = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic irq, pins, mst, tx;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  i2c_mode_ctl u_i2c_mode_ctl (
    .clk_i(clk), .rst_ni, .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .start_det_i(start), .stop_det_i(stop), .frame_done_i(fdone), .arb_lost_i(arb),
    .rw_valid_i(rwv), .rw_bit_i(rwb), .irq_src_i(isrc), .irq_o(irq),
    .pins_en_o(pins), .mst_o(mst), .tx_o(tx)
  );

  // reference model
  bit m_en, m_ie, m_mst, m_tx, m_act, m_first, m_pend, m_pval;
  bit [7:0] m_addr_regs [2], m_md_regs [2];

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      {m_en, m_ie, m_mst, m_tx, m_act, m_first, m_pend, m_pval} = '0;
      m_addr_regs = '{default: 0};
      m_md_regs   = '{default: 0};
    end else begin : step
      bit n_mst, n_tx, n_pend, n_pval, n_act, n_first, rw_ok, arb_ok, ctl;
      n_mst = m_mst; n_tx = m_tx; n_pend = m_pend; n_pval = m_pval;
      ctl = we && addr == 0;
      if (m_en && m_pend && (fdone || stop)) begin n_tx = m_pval; n_pend = 0; end
      if (ctl) begin
        n_mst = wdata[5];
        if (m_en && m_act) begin n_pend = 1; n_pval = wdata[4]; end
        else n_tx = wdata[4];
      end
      rw_ok  = m_en && rwv && m_first && !m_mst && !m_tx && !m_addr_regs[0][0];
      arb_ok = m_en && arb && m_mst;
      if (rw_ok) begin n_tx = rwb; n_pend = 0; end
      if (arb_ok) begin n_mst = 0; n_tx = 0; n_pend = 0; end
      if (!m_en) n_pend = 0;
      n_act   = m_en && (start || (m_act && !stop));
      n_first = m_en && (start || (m_first && !fdone));
      if (we && (addr == 1 || addr == 2)) begin
        if (m_en) m_md_regs[addr-1] = wdata; else m_addr_regs[addr-1] = wdata;
      end
      if (ctl) begin m_en = wdata[7]; m_ie = wdata[6]; end
      m_mst = n_mst; m_tx = n_tx; m_pend = n_pend; m_pval = n_pval;
      m_act = n_act; m_first = n_first;
    end
  end

  function automatic bit [7:0] exp_rdata();
    case (addr)
      2'd0: return {m_en, m_ie, m_mst, m_tx, 4'b0};
      2'd1, 2'd2: return m_en ? m_md_regs[addr-1] : m_addr_regs[addr-1];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_ni && !done) begin
    chk("R10 mode bits", {6'b0, mst, tx}, {6'b0, m_mst, m_tx});
    chk("R4 irq", {7'b0, irq}, {7'b0, isrc & m_ie & m_en});
    chk("R2 pins_en", {7'b0, pins}, {7'b0, m_en});
    chk("R3 rdata", rdata, exp_rdata());
  end

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic idle();
    we = 0; start = 0; stop = 0; fdone = 0; arb = 0; rwv = 0; rwb = 0;
  endtask
  task automatic wr(logic [1:0] a, logic [7:0] d);
    we = 1; addr = a; wdata = d; tick(); we = 0;
  endtask
  task automatic pulse(ref logic s); s = 1; tick(); s = 0; endtask
  task automatic rd_at(logic [1:0] a); addr = a; @(negedge clk); endtask

  initial begin
    #25 rst_ni = 1; tick();
    // R1 reset state
    rd_at(0); chk("R1 ctrl reset", rdata, 8'h00);
    chk("R1 outputs", {pins, irq, mst, tx}, 4'b0);
    // R3 address set while disabled (format bit 0 = 0)
    wr(1, 8'h50); wr(2, 8'h33);
    rd_at(1); chk("R3 primary addr", rdata, 8'h50);
    rd_at(2); chk("R3 extended addr", rdata, 8'h33);
    rd_at(3); chk("R3 offset3", rdata, 8'h00);
    // R2 events ignored while disabled
    pulse(start); rwv = 1; rwb = 1; tick(); idle();
    chk("R2 rw ignored while disabled", {7'b0, tx}, 8'h00);
    // enable, master transmit
    wr(0, 8'hF0); rd_at(0); chk("R10 ctrl readback", rdata, 8'hF0);
    chk("R2 pins driven", {7'b0, pins}, 8'h01);
    wr(1, 8'hA5); wr(2, 8'h5A);
    rd_at(1); chk("R3 mode reg", rdata, 8'hA5);
    rd_at(2); chk("R3 data reg", rdata, 8'h5A);
    // R4 irq gating
    isrc = 1; @(negedge clk); chk("R4 irq on", {7'b0, irq}, 8'h01);
    wr(0, 8'hB0); @(negedge clk); chk("R4 irq masked", {7'b0, irq}, 8'h00);
    isrc = 0; wr(0, 8'hF0);
    // R7 deferral
    pulse(start); wr(0, 8'hE0);
    @(negedge clk); chk("R7 tx held", {7'b0, tx}, 8'h01);
    tick(); chk("R7 tx still held", {7'b0, tx}, 8'h01);
    pulse(fdone); @(negedge clk); chk("R7 applied at frame end", {7'b0, tx}, 8'h00);
    // R5 arbitration loss
    wr(0, 8'hF0); pulse(arb);
    @(negedge clk); chk("R5 slave rx", {6'b0, mst, tx}, 8'h00);
    // R6 rw loads tx on first frame only
    pulse(stop); pulse(start); rwv = 1; rwb = 1; tick(); idle();
    @(negedge clk); chk("R6 rw=1 -> tx", {7'b0, tx}, 8'h01);
    pulse(fdone); wr(0, 8'hC0); pulse(stop);  // pending tx=0 applied at stop (R8)
    @(negedge clk); chk("R8 stop applies pending", {7'b0, tx}, 8'h00);
    rwv = 1; rwb = 1; tick(); idle();
    chk("R6 rw outside first frame ignored", {7'b0, tx}, 8'h00);
    // R8 immediate when idle
    wr(0, 8'hD0); @(negedge clk); chk("R8 immediate tx", {7'b0, tx}, 8'h01);
    wr(0, 8'hC0);
    // R9 rw override with pending, same cycle as frame end
    pulse(start); wr(0, 8'hD0);
    rwv = 1; rwb = 0; fdone = 1; tick(); idle();
    @(negedge clk); chk("R9 rw wins", {7'b0, tx}, 8'h00);
    pulse(fdone); @(negedge clk); chk("R9 pending discarded", {7'b0, tx}, 8'h00);
    // R9 arbitration override while pending
    wr(0, 8'hF0); pulse(arb); pulse(fdone);
    @(negedge clk); chk("R9 arb drops pending", {6'b0, mst, tx}, 8'h00);
    pulse(stop);
    // R2 disable
    wr(0, 8'h00); @(negedge clk); chk("R2 pins released", {7'b0, pins}, 8'h00);
    rd_at(1); chk("R3 addr untouched by mode write", rdata, 8'h50);
    wr(1, 8'h51); wr(0, 8'h80); rd_at(1); chk("R3 mode untouched", rdata, 8'hA5);
    tick(); tick();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule